// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Status Flags

This block is the integer ALU of a small processor core. Each accepted request carries an operation code, a width select (byte or word), a destination operand, a source operand and the current flag word. One clock later it returns three things: the result, a write-enable for the destination register, and the next flag word. The operations are add, subtract, compare, increment, decrement, negate, AND, OR, XOR and NOT.

Each operation has its own rule for the status flags. Increment and decrement preserve carry. The bitwise operations clear carry, overflow and auxiliary carry. Negate sets carry only for a non-zero operand. NOT leaves every flag alone. Compare sets the flags like subtract but raises no write. The trap, interrupt-enable and direction bits and all reserved bits of the flag word are carried through untouched. The unary operations act on the destination operand.

Top module: `byte_word_alu`

## Requirements
- R1: The status flags of the flag word sit at fixed bits: carry at bit 0, parity at bit 2, auxiliary carry at bit 4, zero at bit 6, sign at bit 7 and overflow at bit 11. Zero is set when the result is zero. Sign copies the most significant result bit. Parity is set when the low result byte has an even count of ones.
- R2: With `wide`=0, only the low bytes of the operands are used, `result[15:8]` is 0, and carry, sign and overflow are taken at bit 7. With `wide`=1, all 16 bits are used and those flags are taken at bit 15.
- R3: Add (code 0) and subtract (code 1) compute dst+src and dst-src. Carry is the carry out of, or borrow into, the top bit. Auxiliary carry is the carry or borrow across bit 3. Overflow flags a two's-complement overflow.
- R4: Increment (code 3) and decrement (code 4) compute dst+1 and dst-1 and set the flags as add or subtract would, except that carry keeps its incoming value.
- R5: Negate (code 5) gives 0-dst. Carry is 1 for a non-zero operand and 0 for zero; for example, 15h gives EBh.
- R6: AND (6), OR (7) and XOR (8) clear carry, overflow and auxiliary carry, and set zero, sign and parity from the result; for example, 61h AND CFh gives 41h.
- R7: NOT (code 9) inverts dst and returns the incoming flag word unchanged; for example, 39h gives C6h.
- R8: Compare (code 2) sets the flags as subtract does and outputs the difference on `result`, but holds `result_we` at 0. Every other valid code raises `result_we`.
- R9: Flag bits 1, 3, 5, 8, 9, 10 and 12 to 15 leave the block exactly as they entered, for every code.
- R10: Codes 10 to 15 are not operations: `result` is 0, `result_we` is 0 and the flag word is returned unchanged.
- R11: A request presented with `in_valid` high is answered one clock later with `out_valid` high. While reset is held (active-low `rst_n`), all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| opcode | input | 4 | Operation code |
| wide | input | 1 | 1 = word operation, 0 = byte operation |
| dst | input | 16 | Destination operand (sole operand of the unary codes) |
| src | input | 16 | Source operand |
| flags_in | input | 16 | Current flag word |
| out_valid | output | 1 | Answer present this cycle |
| result | output | 16 | Operation result |
| result_we | output | 1 | Write the result to the destination |
| flags_out | output | 16 | Next flag word |

## Verification
The add and subtract paths are driven with operands chosen to separate the flags that are easy to confuse. Adding 7Fh+01h in byte mode sets overflow and auxiliary carry without carry. Adding FFh+01h sets carry and zero without overflow. The same sums in word mode show that the top bit moves to bit 15. Increment and decrement are run with the incoming carry both set and clear, and negate is run with 0, 15h and the most negative value, so that the carry and overflow exceptions of these codes are seen on their own. The bitwise codes, NOT, compare and the unused codes are run with flag words full of ones and full of zeros, so that a flag that should have been cleared, kept or passed through is exposed. A long stream of random codes, widths and operands then checks that all cases agree with a reference model.

// File: rtl/byte_word_alu.sv
module byte_word_alu #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    opcode,
  input  logic          wide,
  input  logic [DW-1:0] dst,
  input  logic [DW-1:0] src,
  input  logic [15:0]   flags_in,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic          result_we,
  output logic [15:0]   flags_out
);
  localparam int HB = DW / 2;
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_CMP = 4'd2,
                         OP_INC = 4'd3, OP_DEC = 4'd4, OP_NEG = 4'd5,
                         OP_AND = 4'd6, OP_OR  = 4'd7, OP_XOR = 4'd8,
                         OP_NOT = 4'd9;
  localparam int B_CF = 0, B_PF = 2, B_AF = 4, B_ZF = 6, B_SF = 7, B_OF = 11;

  logic [DW-1:0] a, b, x, y, r;
  logic [DW:0]   sum;
  logic          sub, arith, logic_op, keep_cf, legal, we;
  logic          xm, ym, rm, cout, ovf, aux;
  logic [15:0]   fl;

  assign a = wide ? dst : {{HB{1'b0}}, dst[HB-1:0]};
  assign b = wide ? src : {{HB{1'b0}}, src[HB-1:0]};

  always_comb begin
    x = a; y = b; sub = 1'b0; arith = 1'b1; logic_op = 1'b0;
    keep_cf = 1'b0; legal = 1'b1; we = 1'b1;
    case (opcode)
      OP_ADD: ;
      OP_SUB: sub = 1'b1;
      OP_CMP: begin sub = 1'b1; we = 1'b0; end
      OP_INC: begin y = DW'(1); keep_cf = 1'b1; end
      OP_DEC: begin y = DW'(1); sub = 1'b1; keep_cf = 1'b1; end
      OP_NEG: begin x = '0; y = a; sub = 1'b1; end
      OP_AND, OP_OR, OP_XOR: begin arith = 1'b0; logic_op = 1'b1; end
      OP_NOT: arith = 1'b0;
      default: begin arith = 1'b0; legal = 1'b0; we = 1'b0; end
    endcase
  end

  assign sum = sub ? ({1'b0, x} - {1'b0, y}) : ({1'b0, x} + {1'b0, y});

  always_comb begin
    case (opcode)
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_NOT:  r = wide ? ~a : {{HB{1'b0}}, ~a[HB-1:0]};
      default: r = (arith && legal) ? (wide ? sum[DW-1:0] : {{HB{1'b0}}, sum[HB-1:0]}) : '0;
    endcase
  end

  assign xm   = wide ? x[DW-1] : x[HB-1];
  assign ym   = wide ? y[DW-1] : y[HB-1];
  assign rm   = wide ? r[DW-1] : r[HB-1];
  assign cout = wide ? sum[DW] : sum[HB];
  assign ovf  = sub ? ((xm != ym) && (rm != xm)) : ((xm == ym) && (rm != xm));
  assign aux  = x[4] ^ y[4] ^ sum[4];

  always_comb begin
    fl = flags_in;
    if (arith || logic_op) begin
      fl[B_ZF] = (r == '0);
      fl[B_SF] = rm;
      fl[B_PF] = ~^r[7:0];
      fl[B_CF] = arith ? (keep_cf ? flags_in[B_CF] : cout) : 1'b0;
      fl[B_AF] = arith ? aux : 1'b0;
      fl[B_OF] = arith ? ovf : 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      result_we <= 1'b0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= r;
        result_we <= we;
        flags_out <= fl;
      end
    end
  end
endmodule

// File: rtl/byte_word_alu_checks.sv
module byte_word_alu_checks #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [3:0]    opcode,
  input logic [15:0]   flags_in,
  input logic          out_valid,
  input logic [DW-1:0] result,
  input logic          result_we,
  input logic [15:0]   flags_out
);
  localparam logic [15:0] PASS_MASK = 16'hF72A;

  AST_RESPONSE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R11
  AST_CTRL_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((flags_out & PASS_MASK) == ($past(flags_in) & PASS_MASK))); // R9
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 4'd2) |=> !result_we); // R8
  AST_NOT_FLAGS_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 4'd9) |=> (flags_out == $past(flags_in))); // R7
  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode >= 4'd6 && opcode <= 4'd8) |=> (!flags_out[0] && !flags_out[4] && !flags_out[11])); // R6
  AST_STEP_KEEPS_CF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode == 4'd3 || opcode == 4'd4)) |=> (flags_out[0] == $past(flags_in[0]))); // R4
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode <= 4'd8) |=> (flags_out[6] == (result == '0))); // R1
  AST_UNUSED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode >= 4'd10) |=> (!result_we && flags_out == $past(flags_in))); // R10
endmodule

bind byte_word_alu byte_word_alu_checks #(.DW(DW)) u_checks (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
  .flags_in(flags_in), .out_valid(out_valid), .result(result),
  .result_we(result_we), .flags_out(flags_out)
);

// File: tb/tb_byte_word_alu.sv
module tb_byte_word_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  opcode = '0;
  logic        wide = 1'b0;
  logic [15:0] dst = '0, src = '0, flags_in = '0;
  logic        out_valid, result_we;
  logic [15:0] result, flags_out;

  int total = 0, bad = 0;
  bit finished = 0;

  typedef struct {
    logic [15:0] res;
    logic        we;
    logic [15:0] fl;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  byte_word_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .wide(wide), .dst(dst), .src(src), .flags_in(flags_in),
    .out_valid(out_valid), .result(result), .result_we(result_we),
    .flags_out(flags_out)
  );

  function automatic exp_t model(input logic [3:0] op, input logic w,
                                 input logic [15:0] d, input logic [15:0] s,
                                 input logic [15:0] fin, input string tag);
    exp_t e;
    int m, top, a, bb, x, y, r, sx, sy, sr, ones;
    bit sub, ar, lg, cf, af, of;
    m = w ? 65535 : 255;
    top = w ? 32768 : 128;
    a = int'(d) & m;
    bb = int'(s) & m;
    e.fl = fin; e.we = 1'b1; e.tag = tag;
    sub = 0; ar = 1; lg = 0; x = a; y = bb; r = 0;
    case (op)
      4'd0: ;
      4'd1: sub = 1;
      4'd2: begin sub = 1; e.we = 1'b0; end
      4'd3: y = 1;
      4'd4: begin y = 1; sub = 1; end
      4'd5: begin x = 0; y = a; sub = 1; end
      4'd6: begin ar = 0; lg = 1; r = a & bb; end
      4'd7: begin ar = 0; lg = 1; r = a | bb; end
      4'd8: begin ar = 0; lg = 1; r = a ^ bb; end
      4'd9: begin ar = 0; r = (~a) & m; end
      default: begin ar = 0; e.we = 1'b0; end
    endcase
    cf = 0; af = 0; of = 0;
    if (ar) begin
      sx = (x >= top) ? x - 2*top : x;
      sy = (y >= top) ? y - 2*top : y;
      if (sub) begin
        cf = x < y; af = (x & 15) < (y & 15); r = (x - y) & m; sr = sx - sy;
      end else begin
        cf = (x + y) > m; af = ((x & 15) + (y & 15)) > 15; r = (x + y) & m; sr = sx + sy;
      end
      of = (sr >= top) || (sr < -top);
      if (op == 4'd3 || op == 4'd4) cf = fin[0];
    end
    e.res = 16'(r);
    if (ar || lg) begin
      ones = 0;
      for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
      e.fl[0] = cf; e.fl[2] = (ones % 2) == 0; e.fl[4] = af;
      e.fl[6] = (r == 0); e.fl[7] = (r & top) != 0; e.fl[11] = of;
    end
    return e;
  endfunction

  task automatic send(input logic [3:0] op, input logic w, input logic [15:0] d,
                      input logic [15:0] s, input logic [15:0] fin, input string tag);
    @(negedge clk);
    opcode = op; wide = w; dst = d; src = s; flags_in = fin; in_valid = 1'b1;
    sb.push_back(model(op, w, d, s, fin, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      total++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL R11: unexpected response result=%h expected no response", result);
      end else begin
        e = sb.pop_front();
        if (result !== e.res || result_we !== e.we || flags_out !== e.fl) begin
          bad++;
          $display("FAIL %s: result=%h we=%b flags=%h expected result=%h we=%b flags=%h",
                   e.tag, result, result_we, flags_out, e.res, e.we, e.fl);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R11: watchdog expired, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || result !== 16'h0 || result_we !== 1'b0 || flags_out !== 16'h0) begin
      bad++;
      $display("FAIL R11: reset outputs %b %h %b %h expected 0 0 0 0", out_valid, result, result_we, flags_out);
    end
    rst_n = 1'b1;

    send(4'd0, 1'b0, 16'h007F, 16'h0001, 16'h0000, "R3");
    send(4'd0, 1'b0, 16'hAAFF, 16'h5501, 16'h0000, "R2");
    send(4'd0, 1'b1, 16'h7FFF, 16'h0001, 16'h0000, "R2");
    send(4'd0, 1'b1, 16'hFFFF, 16'h0001, 16'h0000, "R1");
    send(4'd1, 1'b0, 16'h0005, 16'h0002, 16'h0000, "R3");
    send(4'd1, 1'b1, 16'h8000, 16'h0001, 16'h0000, "R3");
    send(4'd2, 1'b1, 16'h1234, 16'h1234, 16'hFFFF, "R8");
    send(4'd2, 1'b0, 16'h0010, 16'h0020, 16'h0000, "R8");
    send(4'd3, 1'b0, 16'h00FF, 16'h0000, 16'h0001, "R4");
    send(4'd3, 1'b0, 16'h00FF, 16'h0000, 16'h0000, "R4");
    send(4'd4, 1'b1, 16'h0000, 16'h0000, 16'h0000, "R4");
    send(4'd5, 1'b0, 16'h0015, 16'h0000, 16'h0000, "R5");
    send(4'd5, 1'b1, 16'h0000, 16'h0000, 16'hFFFF, "R5");
    send(4'd5, 1'b0, 16'h0080, 16'h0000, 16'h0000, "R5");
    send(4'd6, 1'b0, 16'h0061, 16'h00CF, 16'hFFFF, "R6");
    send(4'd7, 1'b1, 16'h8000, 16'h0001, 16'h0811, "R6");
    send(4'd8, 1'b1, 16'h5A5A, 16'h5A5A, 16'hFFFF, "R6");
    send(4'd9, 1'b0, 16'h0039, 16'h0000, 16'h08D5, "R7");
    send(4'd9, 1'b1, 16'h0000, 16'h0000, 16'hFFFF, "R7");
    send(4'd0, 1'b1, 16'h0001, 16'h0001, 16'hF72A, "R9");
    send(4'd10, 1'b1, 16'h1111, 16'h2222, 16'hA5A5, "R10");
    send(4'd15, 1'b0, 16'h00FF, 16'h00FF, 16'h5A5A, "R10");
    idle();
    @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R11: out_valid=%b after idle expected 0", out_valid);
    end
    for (int k = 0; k < 400; k++)
      send(4'($urandom_range(0, 15)), 1'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), "R3");
    idle();
    repeat (3) @(negedge clk);
    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R11: %0d responses missing expected 0", sb.size());
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule